// File: doc/BRIEF.md
# Single-Entry Store Buffer

This block sits between the store path of a processor pipeline and the write port of a single-ported data array. It holds one store (word address, data and byte enables) while the cache controller compares its tag. The store is taken into the buffer in the cycle it is presented, together with its tag result. The buffered write goes into the array in the first later cycle in which no load uses the array. Because a store cycle never reads the array, a new store always pushes the previous entry into the array in its own cycle. Stores can therefore issue every cycle with no stall.

A load that arrives while an entry is pending reads the array as usual. Its result comes back one cycle later. For every byte the pending entry enables, the result takes the buffered byte when the word addresses match, so a load never sees stale data. A store whose tag compare misses is dropped and never reaches the array. A flush request holds off new stores until the entry has drained, and the empty flag then rises.

The controller has three states. EMPTY means no entry is held. HELD means an entry waits for a load-free cycle. FLUSH means a flush arrived while a load kept the entry from draining. The transitions are:
- EMPTY→HELD on an accepted store with a hit.
- HELD→HELD on an accepted store with a hit, which drains the old entry and captures the new one.
- HELD→HELD on a load cycle without flush.
- HELD→EMPTY on a load-free cycle, or on an accepted store that missed.
- HELD→FLUSH on a load cycle with flush raised.
- FLUSH→EMPTY on the first load-free cycle.
- FLUSH→FLUSH while loads continue.

Top module: `stbuf_top`

## Requirements
- R1: After reset `empty`=1, `st_ready`=1, `arr_we`=0 and `ld_rvalid`=0.
- R2: A store taken with `st_valid`=1, `st_ready`=1, `st_hit`=1 into an empty buffer does not write the array in that cycle, and `empty` is 0 from the next cycle.
- R3: A pending entry is written during the first cycle with `ld_valid`=0: `arr_we`=1 with the entry's address, data and byte enables, and `empty` is 1 from the next cycle. No write happens in any cycle with `ld_valid`=1. A store and a load are never presented in the same cycle.
- R4: A store taken while an entry is pending writes the old entry to the array in that same cycle. `st_ready` stays 1, so stores can be presented on consecutive cycles.
- R5: A store taken with `st_hit`=0 is never written to the array, and the buffer is empty afterwards. An entry that was already pending is still written in that cycle.
- R6: `arr_re`/`arr_raddr` follow `ld_valid`/`ld_addr` in the same cycle. `ld_rvalid` is 1 exactly one cycle after `ld_valid`. Byte i of `ld_rdata` (bits 8i+7..8i) comes from the pending entry if its address equals the load address and its byte enable i is 1. Otherwise the byte comes from `arr_rdata` of that result cycle.
- R7: A load to an address other than the pending entry's returns the array data unchanged.
- R8: While `flush`=1, or while a flush waits behind loads, `st_ready`=0. A store presented then is ignored and never written. `empty` rises in the cycle after the entry drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_ready | output | 1 | Store can be taken this cycle |
| st_hit | input | 1 | Tag compare result for the presented store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | BW | Store byte enables |
| ld_valid | input | 1 | Load presented this cycle |
| ld_addr | input | AW | Load word address |
| ld_rvalid | output | 1 | Load result valid (one cycle after the load) |
| ld_rdata | output | DW | Load result with pending bytes merged |
| flush | input | 1 | Request to drain the buffer |
| empty | output | 1 | No entry pending |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | AW | Array write address |
| arr_wdata | output | DW | Array write data |
| arr_wbe | output | BW | Array write byte enables |
| arr_re | output | 1 | Array read enable |
| arr_raddr | output | AW | Array read address |
| arr_rdata | input | DW | Array read data, one cycle after `arr_re` |

## Verification
A wrong controller state shows at the ports in the next cycle or sooner. If the buffer wrongly thinks it is empty, the pending write never appears on `arr_we` in the load-free cycle where it is due. If it wrongly thinks it holds an entry, a write appears in a cycle with nothing to write, or `empty` stays low. A stale or badly captured entry shows up as wrong address, data or byte-enable values on the array write port, or as wrongly merged bytes in the load result one cycle after the load. A flush that does not block stores lets an ignored store reach the array, which a later load of that address exposes.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY = 2'd0,
        SB_HELD  = 2'd1,
        SB_FLUSH = 2'd2
    } sb_state_t;

endpackage

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
    import stbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      st_valid,
    input  logic      st_hit,
    input  logic      ld_valid,
    input  logic      flush,
    output logic      st_ready,
    output logic      capture,
    output logic      drain,
    output logic      holding,
    output sb_state_t state
);

    sb_state_t state_q;
    sb_state_t state_d;
    logic      st_fire;

    always_comb begin
        st_fire = st_valid && (state_q != SB_FLUSH) && !flush;
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: begin
                if (st_fire && st_hit) begin
                    state_d = SB_HELD;
                end
            end
            SB_HELD: begin
                if (st_fire) begin
                    state_d = st_hit ? SB_HELD : SB_EMPTY;
                end else if (!ld_valid) begin
                    state_d = SB_EMPTY;
                end else if (flush) begin
                    state_d = SB_FLUSH;
                end
            end
            SB_FLUSH: begin
                if (!ld_valid) begin
                    state_d = SB_EMPTY;
                end
            end
            default: state_d = SB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        st_ready = 1'b0;
        capture  = 1'b0;
        drain    = 1'b0;
        holding  = 1'b0;
        unique case (state_q)
            SB_EMPTY: begin
                st_ready = !flush;
                capture  = st_fire && st_hit;
            end
            SB_HELD: begin
                st_ready = !flush;
                capture  = st_fire && st_hit;
                drain    = !ld_valid;
                holding  = 1'b1;
            end
            SB_FLUSH: begin
                drain    = !ld_valid;
                holding  = 1'b1;
            end
            default: begin
                st_ready = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/stbuf_entry.sv
module stbuf_entry #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [BW-1:0] in_be,
    output logic [AW-1:0] e_addr,
    output logic [DW-1:0] e_data,
    output logic [BW-1:0] e_be
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_addr <= '0;
            e_data <= '0;
            e_be   <= '0;
        end else if (capture) begin
            e_addr <= in_addr;
            e_data <= in_data;
            e_be   <= in_be;
        end
    end

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          holding,
    input  logic [AW-1:0] e_addr,
    input  logic [DW-1:0] e_data,
    input  logic [BW-1:0] e_be,
    input  logic [DW-1:0] arr_rdata,
    output logic          ld_rvalid,
    output logic [DW-1:0] ld_rdata
);

    localparam int BYTE_W = DW / BW;

    logic          match;
    logic          rvalid_q;
    logic [BW-1:0] fmask_q;
    logic [DW-1:0] fdata_q;

    assign match = ld_valid && holding && (ld_addr == e_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            fmask_q  <= '0;
            fdata_q  <= '0;
        end else begin
            rvalid_q <= ld_valid;
            fmask_q  <= match ? e_be : '0;
            fdata_q  <= e_data;
        end
    end

    for (genvar b = 0; b < BW; b++) begin : g_byte
        assign ld_rdata[b*BYTE_W +: BYTE_W] = fmask_q[b] ? fdata_q[b*BYTE_W +: BYTE_W]
                                                         : arr_rdata[b*BYTE_W +: BYTE_W];
    end

    assign ld_rvalid = rvalid_q;

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
    import stbuf_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic          st_hit,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rvalid,
    output logic [DW-1:0] ld_rdata,
    input  logic          flush,
    output logic          empty,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output logic [BW-1:0] arr_wbe,
    output logic          arr_re,
    output logic [AW-1:0] arr_raddr,
    input  logic [DW-1:0] arr_rdata
);

    sb_state_t     state;
    logic          capture;
    logic          drain;
    logic          holding;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    logic [BW-1:0] e_be;

    stbuf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_hit   (st_hit),
        .ld_valid (ld_valid),
        .flush    (flush),
        .st_ready (st_ready),
        .capture  (capture),
        .drain    (drain),
        .holding  (holding),
        .state    (state)
    );

    stbuf_entry #(.AW(AW), .DW(DW), .BW(BW)) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .in_addr (st_addr),
        .in_data (st_data),
        .in_be   (st_be),
        .e_addr  (e_addr),
        .e_data  (e_data),
        .e_be    (e_be)
    );

    stbuf_fwd #(.AW(AW), .DW(DW), .BW(BW)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .holding   (holding),
        .e_addr    (e_addr),
        .e_data    (e_data),
        .e_be      (e_be),
        .arr_rdata (arr_rdata),
        .ld_rvalid (ld_rvalid),
        .ld_rdata  (ld_rdata)
    );

    assign empty     = (state == SB_EMPTY);
    assign arr_we    = drain;
    assign arr_waddr = e_addr;
    assign arr_wdata = e_data;
    assign arr_wbe   = e_be;
    assign arr_re    = ld_valid;
    assign arr_raddr = ld_addr;

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          st_hit,
    input logic          ld_valid,
    input logic          ld_rvalid,
    input logic          flush,
    input logic          empty,
    input logic          arr_we
);

    assert_single_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && st_ready && ld_valid));

    assert_no_write_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !arr_we);

    assert_idle_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !ld_valid && !(st_valid && st_ready)) |=> empty);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_hit) |=> !empty);

    assert_drain_on_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !empty) |-> arr_we);

    assert_ready_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !flush) |-> st_ready);

    assert_miss_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !st_hit) |=> empty);

    assert_rvalid_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_rvalid);

    assert_rvalid_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_rvalid);

    assert_ignored_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready && empty) |=> empty);

    assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !st_ready);

endmodule

bind stbuf_top stbuf_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_hit    (st_hit),
    .ld_valid  (ld_valid),
    .ld_rvalid (ld_rvalid),
    .flush     (flush),
    .empty     (empty),
    .arr_we    (arr_we)
);

// File: tb/stbuf_top_tb.sv
module stbuf_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid, st_ready, st_hit;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [BW-1:0] st_be;
    logic          ld_valid, ld_rvalid;
    logic [AW-1:0] ld_addr;
    logic [DW-1:0] ld_rdata;
    logic          flush, empty;
    logic          arr_we, arr_re;
    logic [AW-1:0] arr_waddr, arr_raddr;
    logic [DW-1:0] arr_wdata;
    logic [BW-1:0] arr_wbe;
    logic [DW-1:0] arr_rdata;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int            n_checks = 0;
    int            n_fail   = 0;
    logic          done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stbuf_top #(.AW(AW), .DW(DW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_hit(st_hit),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
        .flush(flush), .empty(empty),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_wbe(arr_wbe),
        .arr_re(arr_re), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
    );

    function automatic logic [DW-1:0] seed(int a);
        return 32'hA5000000 + a * 32'h00010101;
    endfunction

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = seed(i);
        arr_rdata = '0;
    end

    always @(posedge clk) begin
        if (arr_we) begin
            for (int b = 0; b < BW; b++)
                if (arr_wbe[b]) mem[arr_waddr][b*8 +: 8] <= arr_wdata[b*8 +: 8];
        end
        if (arr_re) arr_rdata <= mem[arr_raddr];
    end

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        st_valid = 0; st_hit = 0; st_addr = '0; st_data = '0; st_be = '0;
        ld_valid = 0; ld_addr = '0; flush = 0;
    endtask

    task automatic put_store(int a, logic [DW-1:0] d, logic [BW-1:0] be, logic hit);
        idle();
        st_valid = 1; st_hit = hit; st_addr = AW'(a); st_data = d; st_be = be;
        #1;
    endtask

    task automatic put_load(int a);
        idle();
        ld_valid = 1; ld_addr = AW'(a);
        #1;
    endtask

    task automatic read_word(string req, int a, logic [DW-1:0] exp);
        put_load(a);
        step();
        idle();
        #1;
        check(req, {31'd0, ld_rvalid}, 32'd1);
        check(req, ld_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 empty", {31'd0, empty}, 32'd1);
        check("R1 st_ready", {31'd0, st_ready}, 32'd1);
        check("R1 arr_we", {31'd0, arr_we}, 32'd0);
        check("R1 ld_rvalid", {31'd0, ld_rvalid}, 32'd0);
    endtask

    task automatic t_single_store();
        put_store(5, 32'h11223344, 4'hF, 1);
        check("R2 no write at capture", {31'd0, arr_we}, 32'd0);
        step();
        idle(); #1;
        check("R2 entry held", {31'd0, empty}, 32'd0);
        check("R3 write enable", {31'd0, arr_we}, 32'd1);
        check("R3 write addr", 32'(arr_waddr), 32'd5);
        check("R3 write data", arr_wdata, 32'h11223344);
        check("R3 write be", 32'(arr_wbe), 32'hF);
        step();
        check("R3 empty after drain", {31'd0, empty}, 32'd1);
        read_word("R3 array updated", 5, 32'h11223344);
    endtask

    task automatic t_load_holdoff();
        put_store(6, 32'hCAFEF00D, 4'hF, 1);
        step();
        for (int k = 0; k < 2; k++) begin
            put_load(7);
            check("R3 no write on load", {31'd0, arr_we}, 32'd0);
            step();
            check("R7 other address", ld_rdata, seed(7));
            check("R3 still pending", {31'd0, empty}, 32'd0);
        end
        idle(); #1;
        check("R3 late write", {31'd0, arr_we}, 32'd1);
        check("R3 late write addr", 32'(arr_waddr), 32'd6);
        step();
        check("R3 empty after late drain", {31'd0, empty}, 32'd1);
    endtask

    task automatic t_forward();
        logic [DW-1:0] exp;
        exp = (seed(8) & 32'hFF00FF00) | (32'hAABBCCDD & 32'h00FF00FF);
        put_store(8, 32'hAABBCCDD, 4'b0101, 1);
        step();
        put_load(8);
        check("R3 hold on load", {31'd0, arr_we}, 32'd0);
        step();
        idle(); #1;
        check("R6 rvalid", {31'd0, ld_rvalid}, 32'd1);
        check("R6 merged bytes", ld_rdata, exp);
        check("R3 drain after load", {31'd0, arr_we}, 32'd1);
        check("R3 drain be", 32'(arr_wbe), 32'h5);
        step();
        check("R6 rvalid drop", {31'd0, ld_rvalid}, 32'd0);
        read_word("R6 merged in array", 8, exp);
    endtask

    task automatic t_back2back();
        put_store(9, 32'h09090909, 4'hF, 1);
        check("R4 ready 1", {31'd0, st_ready}, 32'd1);
        step();
        put_store(10, 32'h10101010, 4'hF, 1);
        check("R4 ready 2", {31'd0, st_ready}, 32'd1);
        check("R4 drain old 1", {31'd0, arr_we}, 32'd1);
        check("R4 drain addr 9", 32'(arr_waddr), 32'd9);
        step();
        put_store(11, 32'h11111111, 4'hF, 1);
        check("R4 ready 3", {31'd0, st_ready}, 32'd1);
        check("R4 drain addr 10", 32'(arr_waddr), 32'd10);
        check("R4 drain data 10", arr_wdata, 32'h10101010);
        step();
        idle(); #1;
        check("R4 final drain addr", 32'(arr_waddr), 32'd11);
        step();
        read_word("R4 word 9", 9, 32'h09090909);
        read_word("R4 word 11", 11, 32'h11111111);
    endtask

    task automatic t_miss();
        put_store(12, 32'h12121212, 4'hF, 1);
        step();
        put_store(13, 32'hDEADBEEF, 4'hF, 0);
        check("R5 old entry written", {31'd0, arr_we}, 32'd1);
        check("R5 old entry addr", 32'(arr_waddr), 32'd12);
        step();
        idle(); #1;
        check("R5 empty after miss", {31'd0, empty}, 32'd1);
        check("R5 no write of miss", {31'd0, arr_we}, 32'd0);
        step();
        read_word("R5 miss not stored", 13, seed(13));
    endtask

    task automatic t_flush();
        put_store(14, 32'h14141414, 4'hF, 1);
        step();
        put_load(0);
        flush = 1; #1;
        check("R8 ready low on flush", {31'd0, st_ready}, 32'd0);
        check("R3 no write under load", {31'd0, arr_we}, 32'd0);
        step();
        put_load(1);
        check("R8 ready low while waiting", {31'd0, st_ready}, 32'd0);
        check("R8 not yet empty", {31'd0, empty}, 32'd0);
        step();
        put_store(15, 32'h15151515, 4'hF, 1);
        check("R8 ready low at drain", {31'd0, st_ready}, 32'd0);
        check("R8 drain during flush", {31'd0, arr_we}, 32'd1);
        check("R8 drain addr", 32'(arr_waddr), 32'd14);
        step();
        idle(); #1;
        check("R8 empty after flush", {31'd0, empty}, 32'd1);
        check("R8 ready again", {31'd0, st_ready}, 32'd1);
        check("R8 ignored store not written", {31'd0, arr_we}, 32'd0);
        step();
        read_word("R8 ignored store", 15, seed(15));
        read_word("R8 flushed word", 14, 32'h14141414);
        flush = 1; #1;
        check("R8 flush on empty", {31'd0, st_ready}, 32'd0);
        check("R8 stays empty", {31'd0, empty}, 32'd1);
        step();
        idle(); #1;
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_single_store();
        t_load_holdoff();
        t_forward();
        t_back2back();
        t_miss();
        t_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule